// File: doc/BRIEF.md
# Small Multicycle 8-bit Processor Core

This block is a complete, minimal 8-bit processor. It has one 16-word memory that holds both instructions and data, a bank of four 8-bit general registers, a four-function arithmetic unit, a 4-bit program counter and an instruction register. Every instruction is one byte. The top two bits select the operation. The remaining six bits name registers, an arithmetic function or a memory address.

A controller steps each instruction through a fixed sequence of states. Fetch, decode and dispatch are common to all instructions. After dispatch, loads take one extra state, stores take one, and arithmetic takes two: one to capture the second operand and one to write the result. Memory is filled through a byte-wide load port that is accepted only while reset is held. Execution starts at address 0 once reset is released. The register contents, program counter, instruction register and controller state are brought out to the ports for observation.

Top module: `tiny_cpu`

## Requirements
- R1: While reset is high, on every rising edge the state output becomes FETCH (code 0), the program counter becomes 0, the instruction register becomes 0 and all four registers become 0. Reset is synchronous and active high.
- R2: A load-port write (`ld_en`=1) stores `ld_data` at `ld_addr` only on edges where reset is high. When reset is low, the load port has no effect on memory.
- R3: Instruction bits [7:6] select the class: 00 no-op, 01 load, 10 store, 11 arithmetic. Every instruction passes through FETCH (0), DECODE (1) and EXECUTE (2) on consecutive cycles. A no-op then returns to FETCH, so it lasts 3 cycles. The state code never exceeds 6.
- R4: For a load, bits [5:4] name the destination register and bits [3:0] give the memory address. The path is EXECUTE then MEMRD (3). The register holds the memory byte from the cycle after MEMRD. A load lasts 4 cycles.
- R5: For a store, bits [5:4] name the source register and bits [3:0] give the address. The path is EXECUTE then MEMWR (4). The memory holds the register value after MEMWR, so a later load of that address returns it. A store lasts 4 cycles.
- R6: For arithmetic, bits [5:4] select the function (00 add, 01 subtract, 10 multiply, 11 divide). Bits [3:2] name operand A, which is also the destination. Bits [1:0] name operand B. The path is EXECUTE, OPB (5), ALUWB (6). Only register A is written. The instruction lasts 5 cycles.
- R7: Add and subtract wrap modulo 256. Multiply keeps the low 8 bits of the product.
- R8: Divide gives the unsigned floor quotient. When the divisor is 0, the result is 8'hFF.
- R9: The program counter changes only on the last cycle of an instruction, and then it increases by exactly 1. It wraps from 15 to 0.
- R10: The instruction register takes the byte at the program-counter address at the end of DECODE and keeps it unchanged in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| ld_en | input | 1 | Load-port write strobe, honoured only during reset |
| ld_addr | input | 4 | Load-port memory address |
| ld_data | input | 8 | Load-port write byte |
| state_o | output | 3 | Controller state code (0 FETCH .. 6 ALUWB) |
| pc_o | output | 4 | Program counter |
| ir_o | output | 8 | Instruction register |
| regs_o | output | 32 | Register file, R0 in bits [7:0] up to R3 in bits [31:24] |

## Verification
The bench builds the core with its default sizes: 8-bit data, a 4-bit address (16 memory words) and four registers. At these sizes, every memory address, every register pairing and the 15-to-0 wrap of the program counter can be reached by programs a few dozen instructions long. Every cycle, a behavioural model that works one instruction at a time predicts the state code, program counter, instruction register and all registers. Directed programs exercise the corner cases: sums, differences and products that wrap, division by zero, a store followed by a load of the same address, and load-port writes issued while the core is running.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int CPU_DW = 8;
    localparam int CPU_AW = 4;
    localparam int CPU_NR = 4;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_MEMRD  = 3'd3,
        ST_MEMWR  = 3'd4,
        ST_OPB    = 3'd5,
        ST_ALUWB  = 3'd6
    } cpu_state_e;

    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_ALU   = 2'b11
    } opclass_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'b00,
        FN_SUB = 2'b01,
        FN_MUL = 2'b10,
        FN_DIV = 2'b11
    } alu_fn_e;

    typedef struct packed {
        opclass_e   cls;
        logic [1:0] fld_hi;
        logic [1:0] fld_mid;
        logic [1:0] fld_lo;
    } instr_t;

    function automatic logic [CPU_AW-1:0] mem_field(instr_t i);
        return CPU_AW'({i.fld_mid, i.fld_lo});
    endfunction

    function automatic logic is_last_cycle(cpu_state_e st, opclass_e cls);
        return (st == ST_MEMRD) || (st == ST_MEMWR) || (st == ST_ALUWB) ||
               ((st == ST_EXEC) && (cls == OP_NOP));
    endfunction

endpackage

// File: rtl/cpu_mem.sv
module cpu_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int DW = 8,
    parameter int NR = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [$clog2(NR)-1:0]  waddr,
    input  logic [DW-1:0]          wdata,
    input  logic [$clog2(NR)-1:0]  raddr0,
    output logic [DW-1:0]          rdata0,
    input  logic [$clog2(NR)-1:0]  raddr1,
    output logic [DW-1:0]          rdata1,
    output logic [NR*DW-1:0]       all_o
);
    logic [DW-1:0] bank [NR];

    for (genvar g = 0; g < NR; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[g] <= '0;
            end else if (we && (waddr == g)) begin
                bank[g] <= wdata;
            end
        end
        assign all_o[g*DW +: DW] = bank[g];
    end

    assign rdata0 = bank[raddr0];
    assign rdata1 = bank[raddr1];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_fn_e       fn,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    always_comb begin
        unique case (fn)
            FN_ADD: y = a + b;
            FN_SUB: y = a - b;
            FN_MUL: y = a * b;
            FN_DIV: y = (b == '0) ? '1 : (a / b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/tiny_cpu.sv
module tiny_cpu
    import cpu_pkg::*;
#(
    parameter int DW = CPU_DW,
    parameter int AW = CPU_AW,
    parameter int NR = CPU_NR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [AW-1:0]    ld_addr,
    input  logic [DW-1:0]    ld_data,
    output logic [2:0]       state_o,
    output logic [AW-1:0]    pc_o,
    output logic [DW-1:0]    ir_o,
    output logic [NR*DW-1:0] regs_o
);
    localparam int RSW = $clog2(NR);

    cpu_state_e    st_q, st_d;
    logic [AW-1:0] pc_q;
    instr_t        ir_q;
    logic [AW-1:0] maddr_q;
    logic [DW-1:0] opb_q;

    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    logic           rf_we;
    logic [RSW-1:0] rf_waddr, rf_ra0, rf_ra1;
    logic [DW-1:0]  rf_wdata, rf_rd0, rf_rd1;
    logic [DW-1:0]  alu_y;
    logic           done;

    // next-state selection
    always_comb begin
        unique case (st_q)
            ST_FETCH:  st_d = ST_DECODE;
            ST_DECODE: st_d = ST_EXEC;
            ST_EXEC: begin
                unique case (ir_q.cls)
                    OP_LOAD:  st_d = ST_MEMRD;
                    OP_STORE: st_d = ST_MEMWR;
                    OP_ALU:   st_d = ST_OPB;
                    default:  st_d = ST_FETCH;
                endcase
            end
            ST_OPB:  st_d = ST_ALUWB;
            default: st_d = ST_FETCH;
        endcase
    end

    assign done = is_last_cycle(st_q, ir_q.cls);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_FETCH;
            pc_q    <= '0;
            ir_q    <= '0;
            maddr_q <= '0;
            opb_q   <= '0;
        end else begin
            st_q <= st_d;
            unique case (st_q)
                ST_FETCH:  maddr_q <= pc_q;
                ST_DECODE: ir_q    <= instr_t'(mem_rdata);
                ST_EXEC: begin
                    if (ir_q.cls == OP_LOAD || ir_q.cls == OP_STORE) begin
                        maddr_q <= mem_field(ir_q);
                    end
                end
                ST_OPB:  opb_q <= rf_rd1;
                default: ;
            endcase
            if (done) begin
                pc_q <= pc_q + 1'b1;
            end
        end
    end

    // memory port: load port owns it during reset
    assign mem_we    = (rst && ld_en) || (!rst && st_q == ST_MEMWR);
    assign mem_addr  = rst ? ld_addr : maddr_q;
    assign mem_wdata = rst ? ld_data : rf_rd0;

    // register file ports
    assign rf_ra0   = (st_q == ST_MEMWR) ? RSW'(ir_q.fld_hi) : RSW'(ir_q.fld_mid);
    assign rf_ra1   = RSW'(ir_q.fld_lo);
    assign rf_we    = (st_q == ST_MEMRD) || (st_q == ST_ALUWB);
    assign rf_waddr = (st_q == ST_MEMRD) ? RSW'(ir_q.fld_hi) : RSW'(ir_q.fld_mid);
    assign rf_wdata = (st_q == ST_MEMRD) ? mem_rdata : alu_y;

    cpu_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    cpu_regfile #(.DW(DW), .NR(NR)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .we     (rf_we),
        .waddr  (rf_waddr),
        .wdata  (rf_wdata),
        .raddr0 (rf_ra0),
        .rdata0 (rf_rd0),
        .raddr1 (rf_ra1),
        .rdata1 (rf_rd1),
        .all_o  (regs_o)
    );

    cpu_alu #(.DW(DW)) u_alu (
        .fn (alu_fn_e'(ir_q.fld_hi)),
        .a  (rf_rd0),
        .b  (opb_q),
        .y  (alu_y)
    );

    assign state_o = st_q;
    assign pc_o    = pc_q;
    assign ir_o    = ir_q;
endmodule

// File: rtl/cpu_chk.sv
module cpu_chk #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    state_o,
    input logic [AW-1:0] pc_o,
    input logic [DW-1:0] ir_o
);
    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd0 |=> state_o == 3'd1); // R3
    AST_DECODE_TO_EXEC: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd1 |=> state_o == 3'd2); // R3
    AST_STATE_RANGE: assert property (@(posedge clk) disable iff (rst)
        state_o <= 3'd6); // R3
    AST_LOAD_PATH: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd2 && ir_o[7:6] == 2'b01) |=> state_o == 3'd3); // R4
    AST_STORE_PATH: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd2 && ir_o[7:6] == 2'b10) |=> state_o == 3'd4); // R5
    AST_ALU_PATH: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd5 |=> state_o == 3'd6); // R6
    AST_NOP_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd2 && ir_o[7:6] == 2'b00) |=>
            (pc_o == AW'($past(pc_o) + 1'b1)) && state_o == 3'd0); // R9
    AST_PC_HOLD_EARLY: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0 || state_o == 3'd1 || state_o == 3'd5) |=> $stable(pc_o)); // R9
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        state_o != 3'd1 |=> $stable(ir_o)); // R10
endmodule

bind tiny_cpu cpu_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .state_o (state_o),
    .pc_o    (pc_o),
    .ir_o    (ir_o)
);

// File: tb/sim_tiny_cpu.sv
`timescale 1ns/1ps
module sim_tiny_cpu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic [2:0]  state_o;
    logic [3:0]  pc_o;
    logic [7:0]  ir_o;
    logic [31:0] regs_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;
    bit m_valid = 0;

    // reference model state (instruction granular)
    int m_pc, m_ir, m_k, m_cur;
    int m_reg [4];
    int m_mem [16];
    logic [7:0] prog [16];

    always #2 clk = ~clk;

    tiny_cpu u0 (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .state_o(state_o), .pc_o(pc_o), .ir_o(ir_o), .regs_o(regs_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ins_len(int cls);
        case (cls)
            0: return 3;
            3: return 5;
            default: return 4;
        endcase
    endfunction

    function automatic int exp_state();
        case (m_k)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return ((m_cur >> 6) == 1) ? 3 : (((m_cur >> 6) == 2) ? 4 : 5);
            default: return 6;
        endcase
    endfunction

    function automatic int arith(int fn, int a, int b);
        case (fn)
            0: return (a + b) & 255;
            1: return (a - b + 256) & 255;
            2: return (a * b) & 255;
            default: return (b == 0) ? 255 : a / b;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pc = 0; m_ir = 0; m_k = 0; m_cur = 0;
            for (int i = 0; i < 4; i++) m_reg[i] = 0;
            if (ld_en) m_mem[ld_addr] = ld_data;
            m_valid = 1;
        end else if (m_valid) begin
            if (m_k == 0) m_cur = m_mem[m_pc];
            if (m_k == 1) m_ir = m_cur;
            if (m_k == ins_len(m_cur >> 6) - 1) begin
                case (m_cur >> 6)
                    1: m_reg[(m_cur >> 4) & 3] = m_mem[m_cur & 15];
                    2: m_mem[m_cur & 15] = m_reg[(m_cur >> 4) & 3];
                    3: m_reg[(m_cur >> 2) & 3] = arith((m_cur >> 4) & 3,
                            m_reg[(m_cur >> 2) & 3], m_reg[m_cur & 3]);
                    default: ;
                endcase
                m_pc = (m_pc + 1) % 16;
                m_k = 0;
            end else begin
                m_k++;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (m_valid && !done_flag) begin
            chk(state_o == 3'(exp_state()), "R3 state", int'(state_o), exp_state());
            chk(pc_o == 4'(m_pc), "R9 pc", int'(pc_o), m_pc);
            chk(ir_o == 8'(m_ir), "R10 ir", int'(ir_o), m_ir);
            for (int i = 0; i < 4; i++)
                chk(regs_o[i*8 +: 8] == 8'(m_reg[i]), "R4/R6 reg", int'(regs_o[i*8 +: 8]), m_reg[i]);
        end
    end

    task automatic load_and_run(input bit keep_ld);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            ld_en = 1'b1; ld_addr = 4'(i); ld_data = prog[i];
            @(negedge clk);
        end
        ld_en = 1'b0;
        @(negedge clk);
        if (keep_ld) begin
            ld_en = 1'b1; ld_addr = 4'd13; ld_data = 8'h77;
        end
        rst = 1'b0;
    endtask

    task automatic wait_fetch(input int pcv);
        int lim = 0;
        do begin
            @(negedge clk);
            lim++;
        end while (!(state_o == 3'd0 && pc_o == 4'(pcv)) && lim < 3000);
        if (lim >= 3000) chk(1'b0, "R9 wait pc", int'(pc_o), pcv);
    endtask

    function automatic logic [7:0] rg(int i);
        return regs_o[i*8 +: 8];
    endfunction

    initial begin
        int n;
        // program A: loads, arithmetic wrap, store/load, divide
        for (int i = 0; i < 16; i++) prog[i] = 8'h00;
        prog[0] = 8'h4E; // LOAD R0,[14]
        prog[1] = 8'h5F; // LOAD R1,[15]
        prog[2] = 8'hC1; // ADD R0,R1
        prog[3] = 8'h6D; // LOAD R2,[13]
        prog[4] = 8'hD9; // SUB R2,R1
        prog[5] = 8'hE5; // MUL R1,R1
        prog[6] = 8'hAC; // STORE R2,[12]
        prog[7] = 8'h7C; // LOAD R3,[12]
        prog[8] = 8'hFC; // DIV R3,R0
        prog[13] = 8'h03;
        prog[14] = 8'hF0;
        prog[15] = 8'h25;
        load_and_run(1'b1);
        wait_fetch(2);
        chk(rg(0) == 8'hF0, "R4 load R0", int'(rg(0)), 'hF0);
        chk(rg(1) == 8'h25, "R4 load R1", int'(rg(1)), 'h25);
        wait_fetch(3);
        chk(rg(0) == 8'h15, "R7 add wrap", int'(rg(0)), 'h15);
        wait_fetch(5);
        chk(rg(2) == 8'hDE, "R2 ld ignored / R7 sub wrap", int'(rg(2)), 'hDE);
        chk(rg(1) == 8'h25, "R6 operand B untouched", int'(rg(1)), 'h25);
        wait_fetch(6);
        chk(rg(1) == 8'h59, "R7 mul low byte", int'(rg(1)), 'h59);
        wait_fetch(8);
        chk(rg(3) == 8'hDE, "R5 store then load", int'(rg(3)), 'hDE);
        wait_fetch(9);
        chk(rg(3) == 8'h0A, "R8 divide", int'(rg(3)), 'h0A);
        // reset with live state
        @(negedge clk);
        ld_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(state_o == 3'd0, "R1 state", int'(state_o), 0);
        chk(pc_o == 4'd0, "R1 pc", int'(pc_o), 0);
        chk(ir_o == 8'd0, "R1 ir", int'(ir_o), 0);
        chk(regs_o == 32'd0, "R1 regs", int'(regs_o), 0);
        // program B: divide by zero, NOP timing, pc wrap
        for (int i = 0; i < 16; i++) prog[i] = 8'h00;
        prog[0] = 8'hF6; // DIV R1,R2 (R2 = 0)
        prog[1] = 8'hC5; // ADD R1,R1
        load_and_run(1'b0);
        wait_fetch(1);
        chk(rg(1) == 8'hFF, "R8 divide by zero", int'(rg(1)), 'hFF);
        wait_fetch(2);
        chk(rg(1) == 8'hFE, "R7 add wrap FF+FF", int'(rg(1)), 'hFE);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(state_o == 3'd0 && pc_o == 4'd0) && n < 1000);
        chk(n == 42, "R3/R9 NOP cycles and wrap", n, 42);
        wait_fetch(1);
        chk(rg(1) == 8'hFF, "R9 rerun after wrap", int'(rg(1)), 'hFF);
        repeat (20) @(negedge clk);
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R3 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule